// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers several active-low external interrupt inputs into a single request line for a CPU. The main source is a dedicated request pin. When the block is built with the merge option, four port pins are combined with it, so that a low on any of them counts as a low on the main source. A separate auxiliary port pin responds to its own falling edges and has its own flag and its own enable.

A byte-wide control and status register holds the two enables, the two latched flags and two write-one acknowledge bits. The flags are cleared only through these acknowledge bits. A build-time option selects how the main source is sensed: on falling edges only, or on falling edges plus a held low level. A synchronized copy of the dedicated pin alone is also brought out, so that the CPU can branch on the pin level.

Register layout:

| Bit | Field | Access |
|-----|-------|--------|
| 7 | main enable | read/write |
| 6 | aux enable | read/write |
| 5:4 | unused | read as 0, writes ignored |
| 3 | main flag | read-only |
| 2 | aux flag | read-only |
| 1 | main acknowledge | write 1 to clear, reads as 0 |
| 0 | aux acknowledge | write 1 to clear, reads as 0 |

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge on the main source sets the main flag (bit 3). The main source is `req_pin_n`, combined as described in R2. The flag is visible on `rd_data` three clock edges after the input change.
- R2: With `MERGE_PORTS=1`, a low on any `port_n` bit acts as a low on the main source.
- R3: A falling edge on `aux_pin_n` sets the aux flag (bit 2). The aux flag raises `irq_o` only while the aux enable (bit 6) is 1.
- R4: After reset, `rd_data` reads 0x80 and `irq_o` is 0. In this state both flags and the aux enable are clear, and the main enable is set.
- R5: A register write has no effect on the flag bits. Writing 1 to bit 1 clears the main flag, and writing 1 to bit 0 clears the aux flag. Bits 5, 4, 1 and 0 always read as 0.
- R6: `irq_o` equals (main flag AND main enable) OR (aux flag AND aux enable). A set flag keeps the request asserted until it is acknowledged.
- R7: `pin_level_o` is the level of `req_pin_n` after two clock edges. It is not affected by `port_n`.
- R8: With `LEVEL_MODE=1`, `irq_o` stays 1 while the main source is held low and the main enable is 1, even after the main flag is acknowledged.
- R9: With `LEVEL_MODE=0`, a main source held low sets the flag only once. After an acknowledge the flag stays clear and `irq_o` stays 0 until a new falling edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_pin_n | input | 1 | Dedicated request pin, active low |
| port_n | input | NPORT | Optional port request pins, active low |
| aux_pin_n | input | 1 | Auxiliary falling-edge request pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request to the CPU |
| pin_level_o | output | 1 | Synchronized level of the dedicated pin |

## Verification
The assertions assume that every pin passes through the synchronizer, so a change in a flag can only follow a detected edge. They also assume that a write happens only on cycles where `wr_en` is high. The bench changes the pins and pulses `wr_en` on falling clock edges. After each change it holds the inputs for several cycles, so that each pin change is seen as exactly one edge. It never applies an acknowledge in the same cycle as a new edge, which keeps the set-over-clear priority out of every expected value.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NPORT       = 4,
  parameter bit MERGE_PORTS = 1'b1,
  parameter bit LEVEL_MODE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_pin_n,
  input  logic [NPORT-1:0] port_n,
  input  logic             aux_pin_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             irq_o,
  output logic             pin_level_o
);
  localparam int B_MEN  = 7;
  localparam int B_AEN  = 6;
  localparam int B_MFLG = 3;
  localparam int B_AFLG = 2;
  localparam int B_MACK = 1;
  localparam int B_AACK = 0;

  logic       main_src_n;
  logic [1:0] main_sync, aux_sync, pin_sync;
  logic       main_prev, aux_prev;
  logic       main_fall, aux_fall;
  logic       main_flag, aux_flag, main_en, aux_en;
  logic       main_ack, aux_ack, main_level;

  generate
    if (MERGE_PORTS) begin : g_merge
      assign main_src_n = req_pin_n & (&port_n);
    end else begin : g_solo
      assign main_src_n = req_pin_n;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_sync <= 2'b11;
      aux_sync  <= 2'b11;
      pin_sync  <= 2'b11;
      main_prev <= 1'b1;
      aux_prev  <= 1'b1;
    end else begin
      main_sync <= {main_sync[0], main_src_n};
      aux_sync  <= {aux_sync[0], aux_pin_n};
      pin_sync  <= {pin_sync[0], req_pin_n};
      main_prev <= main_sync[1];
      aux_prev  <= aux_sync[1];
    end
  end

  assign main_fall  = main_prev & ~main_sync[1];
  assign aux_fall   = aux_prev & ~aux_sync[1];
  assign main_ack   = wr_en & wr_data[B_MACK];
  assign aux_ack    = wr_en & wr_data[B_AACK];
  assign main_level = LEVEL_MODE & ~main_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_en   <= 1'b1;
      aux_en    <= 1'b0;
      main_flag <= 1'b0;
      aux_flag  <= 1'b0;
    end else begin
      if (wr_en) begin
        main_en <= wr_data[B_MEN];
        aux_en  <= wr_data[B_AEN];
      end
      if (main_fall)     main_flag <= 1'b1;
      else if (main_ack) main_flag <= 1'b0;
      if (aux_fall)      aux_flag  <= 1'b1;
      else if (aux_ack)  aux_flag  <= 1'b0;
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[B_MEN]  = main_en;
    rd_data[B_AEN]  = aux_en;
    rd_data[B_MFLG] = main_flag;
    rd_data[B_AFLG] = aux_flag;
  end

  assign irq_o       = (main_en & (main_flag | main_level)) | (aux_en & aux_flag);
  assign pin_level_o = pin_sync[1];
endmodule

module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_o,
  input logic       main_fall,
  input logic       aux_fall,
  input logic       main_flag,
  input logic       aux_flag,
  input logic       aux_en
);
  // R1
  main_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_flag) |-> $past(main_fall));
  // R3
  aux_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_flag) |-> $past(aux_fall));
  // R5
  main_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && !main_fall) |=> !rd_data[3]);
  // R5
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:4] == 2'b00 && rd_data[1:0] == 2'b00);
  // R6
  aux_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_flag && aux_en) |-> irq_o);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_flag && !(wr_en && wr_data[1])) |=> main_flag);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq_o(irq_o), .main_fall(main_fall),
  .aux_fall(aux_fall), .main_flag(main_flag), .aux_flag(aux_flag),
  .aux_en(aux_en)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_pin_n = 1'b1;
  logic [3:0] port_n = 4'hF;
  logic       aux_pin_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, rd_lvl;
  logic       irq_o, pin_level_o, irq_lvl, pin_lvl;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NPORT(4), .MERGE_PORTS(1'b1), .LEVEL_MODE(1'b0)) i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_pin_n(req_pin_n), .port_n(port_n),
    .aux_pin_n(aux_pin_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq_o), .pin_level_o(pin_level_o));

  ext_irq_ctrl #(.NPORT(4), .MERGE_PORTS(1'b0), .LEVEL_MODE(1'b1)) i_lvl (
    .clk(clk), .rst_n(rst_n), .req_pin_n(req_pin_n), .port_n(port_n),
    .aux_pin_n(aux_pin_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_lvl), .irq_o(irq_lvl), .pin_level_o(pin_lvl));

  // {wr, wdata, req_n, port_n, aux_n, exp_rd, exp_irq}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 4'hF, 1'b1, 8'h88, 1'b1}, // R1 edge sets main flag
    {1'b0, 8'h00, 1'b1, 4'hF, 1'b1, 8'h88, 1'b1}, // R6 flag persists
    {1'b1, 8'h88, 1'b1, 4'hF, 1'b1, 8'h88, 1'b1}, // R5 flag write ignored
    {1'b1, 8'h82, 1'b1, 4'hF, 1'b1, 8'h80, 1'b0}, // R5 main ack
    {1'b0, 8'h00, 1'b1, 4'hB, 1'b1, 8'h88, 1'b1}, // R2 merged port pin
    {1'b1, 8'h82, 1'b1, 4'hF, 1'b1, 8'h80, 1'b0}, // R5 main ack
    {1'b1, 8'h80, 1'b1, 4'hF, 1'b0, 8'h84, 1'b0}, // R3 aux flag, disabled
    {1'b1, 8'hC0, 1'b1, 4'hF, 1'b0, 8'hC4, 1'b1}, // R3 aux enabled
    {1'b1, 8'hC1, 1'b1, 4'hF, 1'b1, 8'hC0, 1'b0}, // R5 aux ack
    {1'b1, 8'h00, 1'b0, 4'hF, 1'b1, 8'h08, 1'b0}, // R6 main disabled
    {1'b1, 8'h02, 1'b1, 4'hF, 1'b1, 8'h00, 1'b0}, // R5 ack while disabled
    {1'b1, 8'h80, 1'b1, 4'hF, 1'b1, 8'h80, 1'b0}, // R6 re-enable, no flag
    {1'b1, 8'h7F, 1'b1, 4'hF, 1'b1, 8'h40, 1'b0}, // R5 unused bits zero
    {1'b1, 8'h80, 1'b1, 4'hF, 1'b1, 8'h80, 1'b0}  // R6 restore
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R4 reset rd", rd_data, 8'h80);
    check("R4 reset irq", {7'b0, irq_o}, 8'h00);
    check("R7 reset pin level", {7'b0, pin_level_o}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      req_pin_n = VEC[i][14];
      port_n    = VEC[i][13:10];
      aux_pin_n = VEC[i][9];
      if (VEC[i][23]) pulse_wr(VEC[i][22:15]);
      wait_cyc(4);
      check($sformatf("R1-6 vec%0d rd", i), rd_data, VEC[i][8:1]);
      check($sformatf("R6 vec%0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][0]});
    end

    // R7: only the dedicated pin reaches pin_level_o
    port_n = 4'h0;
    wait_cyc(3);
    check("R7 ports do not move pin level", {7'b0, pin_level_o}, 8'h01);
    port_n = 4'hF;
    wait_cyc(2);
    pulse_wr(8'h82);
    wait_cyc(2);

    // R8 / R9: hold main low, acknowledge
    req_pin_n = 1'b0;
    wait_cyc(2);
    check("R7 pin level low after two edges", {7'b0, pin_level_o}, 8'h00);
    wait_cyc(2);
    check("R8 level flag", rd_lvl, 8'h88);
    check("R1 edge flag", rd_data, 8'h88);
    pulse_wr(8'h82);
    wait_cyc(3);
    check("R8 level irq after ack", {7'b0, irq_lvl}, 8'h01);
    check("R8 level rd after ack", rd_lvl, 8'h80);
    check("R9 edge rd after ack while held", rd_data, 8'h80);
    check("R9 edge irq after ack while held", {7'b0, irq_o}, 8'h00);
    req_pin_n = 1'b1;
    wait_cyc(4);
    check("R8 level irq released", {7'b0, irq_lvl}, 8'h00);
    check("R7 pin level high", {7'b0, pin_level_o}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule